// File: doc/BRIEF.md
# Display Mixer-to-Timing-Channel Router

This block sits between two display mixers and two timing-controller channels in a display pipeline. Each mixer delivers a parallel pixel bus made of data, a valid strobe, a horizontal sync and a vertical sync. A small register port chooses which channel each mixer drives. It also chooses which channel, if any, feeds the HDMI encoder input, and it holds three clock-enable flags for the downstream timing clocks.

Software writes the routing word and the gate/source word through a single-cycle write strobe with an address and data, and reads them back through a combinational read port. A change to a route or a gate takes effect on the clock edge that captures the write. The pixel datapath from that register state to the outputs has no registers in it. When both mixers ask for the same channel, mixer 0 takes it and mixer 1 is left unrouted.

Top module: `disp_route_top`

## Requirements
- R1: The routing word at offset 0x1C holds mixer 0's channel index in bits [1:0] and mixer 1's in bits [5:4]. Output channel n carries the data, valid, hsync and vsync of the mixer whose field equals n.
- R2: When both mixer fields hold the same channel index, that channel carries mixer 0's bus and mixer 1 appears on no channel.
- R3: A channel that no mixer drives outputs zero data, with valid, hsync and vsync low.
- R4: A mixer field of 2 or 3 names no channel, so that mixer is routed nowhere.
- R5: Bits [29:28] of the gate/source word at offset 0x20 pick the HDMI input. Code 0 gives all-zero data with valid and syncs low. Code 1 copies channel 0, code 2 copies channel 1, and code 3 gives the same zeros as code 0.
- R6: In the gate/source word, bit 20 drives the TV channel 0 clock enable, bit 24 the TV channel 1 clock enable, and bit 16 the DSI clock enable.
- R7: After reset every register reads zero. Mixer 0 is then on channel 0, channel 1 is idle, HDMI is disconnected and all three enables are low.
- R8: A write changes the outputs from the edge that captures it, not before. Reads return the last value written, masked to 0x0000_0033 at 0x1C and to 0x3111_0000 at 0x20.
- R9: The word at offset 0x00 stores all 32 bits written, reads them back, and has no effect on routing, HDMI or the enables.
- R10: A write to any other offset changes nothing, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| mix_data | input | 2*DW | Mixer pixel data, mixer m at [m*DW +: DW] |
| mix_valid | input | 2 | Mixer valid, bit per mixer |
| mix_hsync | input | 2 | Mixer horizontal sync |
| mix_vsync | input | 2 | Mixer vertical sync |
| ch_data | output | 2*DW | Channel pixel data, channel c at [c*DW +: DW] |
| ch_valid | output | 2 | Channel valid |
| ch_hsync | output | 2 | Channel horizontal sync |
| ch_vsync | output | 2 | Channel vertical sync |
| hdmi_data | output | DW | HDMI input pixel data |
| hdmi_valid | output | 1 | HDMI input valid |
| hdmi_hsync | output | 1 | HDMI input horizontal sync |
| hdmi_vsync | output | 1 | HDMI input vertical sync |
| clk_en_tv0 | output | 1 | TV channel 0 clock enable |
| clk_en_tv1 | output | 1 | TV channel 1 clock enable |
| clk_en_dsi | output | 1 | DSI clock enable |

## Verification
The two mixers carry different constant data, and their sync bits are set in opposite patterns. Each channel output therefore shows which mixer it carries, or that it is idle. The routing word is tried with straight, swapped, colliding and out-of-range field values. The collision case tells mixer 0 priority apart from a last-writer or OR-merge scheme, and the out-of-range case tells a missing range check apart from a wrap-around. All four HDMI codes are applied over a known routing, so that a code-to-channel off-by-one shows as the wrong mixer's data. Single-bit gate writes catch swapped enable positions. Outputs are sampled both before and after the capturing edge, which pins the one-edge latency.

// File: rtl/disp_route_pkg.sv
package disp_route_pkg;
  localparam int NMIX     = 2;
  localparam int NCH      = 2;
  localparam int CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int REG_W    = 32;

  localparam int OFS_SETUP = 'h00;
  localparam int OFS_PSEL  = 'h1C;
  localparam int OFS_GSRC  = 'h20;

  localparam logic [REG_W-1:0] PSEL_MASK = 32'h0000_0033;
  localparam logic [REG_W-1:0] GSRC_MASK = 32'h3111_0000;

  localparam int BIT_EN_DSI = 16;
  localparam int BIT_EN_TV0 = 20;
  localparam int BIT_EN_TV1 = 24;
  localparam int HDMI_LSB   = 28;

  typedef struct packed {
    logic                hit;
    logic [CH_IDX_W-1:0] idx;
  } pick_t;

  // Which mixer owns channel ch; mixer 0 is tested first and so wins.
  function automatic pick_t route_pick(input int ch, input logic [1:0] s0,
                                       input logic [1:0] s1);
    pick_t p;
    p = '0;
    if (int'(s0) == ch) begin
      p.hit = 1'b1;
      p.idx = CH_IDX_W'(0);
    end else if (int'(s1) == ch) begin
      p.hit = 1'b1;
      p.idx = CH_IDX_W'(1);
    end
    return p;
  endfunction

  // One-based HDMI source code; 0 and codes beyond the channels are open.
  function automatic pick_t hdmi_pick(input logic [1:0] code);
    pick_t p;
    p = '0;
    if (code != 2'd0 && int'(code) <= NCH) begin
      p.hit = 1'b1;
      p.idx = CH_IDX_W'(int'(code) - 1);
    end
    return p;
  endfunction
endpackage

// File: rtl/disp_route_regs.sv
module disp_route_regs
  import disp_route_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  psel_q,
  output logic [REG_W-1:0]  gsrc_q
);
  logic [REG_W-1:0] setup_q;
  logic hit_setup, hit_psel, hit_gsrc;

  assign hit_setup = (addr == ADDR_W'(OFS_SETUP));
  assign hit_psel  = (addr == ADDR_W'(OFS_PSEL));
  assign hit_gsrc  = (addr == ADDR_W'(OFS_GSRC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      psel_q  <= '0;
      gsrc_q  <= '0;
    end else if (wr) begin
      if (hit_setup) setup_q <= wdata;
      if (hit_psel)  psel_q  <= wdata & PSEL_MASK;
      if (hit_gsrc)  gsrc_q  <= wdata & GSRC_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_setup) rdata = setup_q;
    if (hit_psel)  rdata = psel_q;
    if (hit_gsrc)  rdata = gsrc_q;
  end
endmodule

// File: rtl/disp_route_xbar.sv
module disp_route_xbar
  import disp_route_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic [1:0]        sel_m0,
  input  logic [1:0]        sel_m1,
  input  logic [NMIX*DW-1:0] mix_data,
  input  logic [NMIX-1:0]   mix_valid,
  input  logic [NMIX-1:0]   mix_hsync,
  input  logic [NMIX-1:0]   mix_vsync,
  output logic [NCH*DW-1:0] ch_data,
  output logic [NCH-1:0]    ch_valid,
  output logic [NCH-1:0]    ch_hsync,
  output logic [NCH-1:0]    ch_vsync
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pick_t own;
    assign own = route_pick(c, sel_m0, sel_m1);
    always_comb begin
      ch_data[c*DW +: DW] = '0;
      ch_valid[c] = 1'b0;
      ch_hsync[c] = 1'b0;
      ch_vsync[c] = 1'b0;
      if (own.hit) begin
        ch_data[c*DW +: DW] = mix_data[int'(own.idx)*DW +: DW];
        ch_valid[c] = mix_valid[own.idx];
        ch_hsync[c] = mix_hsync[own.idx];
        ch_vsync[c] = mix_vsync[own.idx];
      end
    end
  end
endmodule

// File: rtl/disp_route_hdmi_sel.sv
module disp_route_hdmi_sel
  import disp_route_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic [1:0]        code,
  input  logic [NCH*DW-1:0] ch_data,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH-1:0]    ch_hsync,
  input  logic [NCH-1:0]    ch_vsync,
  output logic [DW-1:0]     hdmi_data,
  output logic              hdmi_valid,
  output logic              hdmi_hsync,
  output logic              hdmi_vsync
);
  pick_t src;
  assign src = hdmi_pick(code);

  always_comb begin
    hdmi_data  = '0;
    hdmi_valid = 1'b0;
    hdmi_hsync = 1'b0;
    hdmi_vsync = 1'b0;
    if (src.hit) begin
      hdmi_data  = ch_data[int'(src.idx)*DW +: DW];
      hdmi_valid = ch_valid[src.idx];
      hdmi_hsync = ch_hsync[src.idx];
      hdmi_vsync = ch_vsync[src.idx];
    end
  end
endmodule

// File: rtl/disp_route_top.sv
module disp_route_top
  import disp_route_pkg::*;
#(
  parameter int DW     = 24,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [2*DW-1:0]     mix_data,
  input  logic [1:0]          mix_valid,
  input  logic [1:0]          mix_hsync,
  input  logic [1:0]          mix_vsync,
  output logic [2*DW-1:0]     ch_data,
  output logic [1:0]          ch_valid,
  output logic [1:0]          ch_hsync,
  output logic [1:0]          ch_vsync,
  output logic [DW-1:0]       hdmi_data,
  output logic                hdmi_valid,
  output logic                hdmi_hsync,
  output logic                hdmi_vsync,
  output logic                clk_en_tv0,
  output logic                clk_en_tv1,
  output logic                clk_en_dsi
);
  logic [REG_W-1:0] psel_q, gsrc_q;
  // Named decode points, observed by the bound checker.
  logic [1:0] sel_m0, sel_m1, hdmi_code;

  disp_route_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .psel_q(psel_q), .gsrc_q(gsrc_q)
  );

  assign sel_m0     = psel_q[1:0];
  assign sel_m1     = psel_q[5:4];
  assign hdmi_code  = gsrc_q[HDMI_LSB +: 2];
  assign clk_en_tv0 = gsrc_q[BIT_EN_TV0];
  assign clk_en_tv1 = gsrc_q[BIT_EN_TV1];
  assign clk_en_dsi = gsrc_q[BIT_EN_DSI];

  disp_route_xbar #(.DW(DW)) u_xbar (
    .sel_m0(sel_m0), .sel_m1(sel_m1),
    .mix_data(mix_data), .mix_valid(mix_valid),
    .mix_hsync(mix_hsync), .mix_vsync(mix_vsync),
    .ch_data(ch_data), .ch_valid(ch_valid),
    .ch_hsync(ch_hsync), .ch_vsync(ch_vsync)
  );

  disp_route_hdmi_sel #(.DW(DW)) u_hdmi (
    .code(hdmi_code),
    .ch_data(ch_data), .ch_valid(ch_valid),
    .ch_hsync(ch_hsync), .ch_vsync(ch_vsync),
    .hdmi_data(hdmi_data), .hdmi_valid(hdmi_valid),
    .hdmi_hsync(hdmi_hsync), .hdmi_vsync(hdmi_vsync)
  );
endmodule

// File: rtl/disp_route_chk.sv
module disp_route_chk
  import disp_route_pkg::*;
#(
  parameter int DW     = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [2*DW-1:0]   mix_data,
  input logic [1:0]        mix_valid,
  input logic [2*DW-1:0]   ch_data,
  input logic [1:0]        ch_valid,
  input logic [DW-1:0]     hdmi_data,
  input logic              hdmi_valid,
  input logic              clk_en_tv0,
  input logic              clk_en_tv1,
  input logic              clk_en_dsi,
  input logic [1:0]        sel_m0,
  input logic [1:0]        sel_m1,
  input logic [1:0]        hdmi_code
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_m0_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_m0) == c) |->
        (ch_data[c*DW +: DW] == mix_data[0 +: DW] && ch_valid[c] == mix_valid[0]));

    assert_m0_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_m0) == c && int'(sel_m1) == c) |->
        (ch_data[c*DW +: DW] == mix_data[0 +: DW]));

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_m0) != c && int'(sel_m1) != c) |->
        (ch_valid[c] == 1'b0 && ch_data[c*DW +: DW] == '0));
  end

  assert_hdmi_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdmi_code == 2'd0 || hdmi_code == 2'd3) |-> (!hdmi_valid && hdmi_data == '0));

  assert_gate_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_GSRC)) |=>
      (clk_en_tv0 == $past(reg_wdata[20]) && clk_en_tv1 == $past(reg_wdata[24]) &&
       clk_en_dsi == $past(reg_wdata[16])));

  assert_route_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(OFS_PSEL)) |=> ($stable(sel_m0) && $stable(sel_m1)));
endmodule

bind disp_route_top disp_route_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_disp_route_top.sv
`timescale 1ns/1ps
module test_disp_route_top;
  localparam int DW = 24;
  localparam logic [DW-1:0] D0 = 24'hA0A0A1;
  localparam logic [DW-1:0] D1 = 24'h5B5B5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2*DW-1:0] mix_data;
  logic [1:0] mix_valid, mix_hsync, mix_vsync;
  logic [2*DW-1:0] ch_data;
  logic [1:0] ch_valid, ch_hsync, ch_vsync;
  logic [DW-1:0] hdmi_data;
  logic hdmi_valid, hdmi_hsync, hdmi_vsync;
  logic clk_en_tv0, clk_en_tv1, clk_en_dsi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign mix_data  = {D1, D0};
  assign mix_valid = 2'b11;
  assign mix_hsync = 2'b01;   // mixer 0 hsync high, mixer 1 low
  assign mix_vsync = 2'b10;   // mixer 0 vsync low, mixer 1 high

  disp_route_top #(.DW(DW), .ADDR_W(8)) i_disp_route_top (.*);

  // Expected 27-bit bus {data, valid, hsync, vsync} for a mixer, or idle.
  function automatic logic [DW+2:0] bus_of(input int m);
    if (m == 0) return {D0, 1'b1, 1'b1, 1'b0};
    if (m == 1) return {D1, 1'b1, 1'b0, 1'b1};
    return '0;
  endfunction

  // Bench view of the routing rule: mixer 0 is considered before mixer 1.
  function automatic int owner(input int c, input int f0, input int f1);
    if (f0 == c) return 0;
    if (f1 == c) return 1;
    return -1;
  endfunction

  function automatic logic [DW+2:0] ch_bus(input int c);
    return {ch_data[c*DW +: DW], ch_valid[c], ch_hsync[c], ch_vsync[c]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic check_routes(input string tag, input int f0, input int f1);
    for (int c = 0; c < 2; c++)
      check($sformatf("%s ch%0d f0=%0d f1=%0d", tag, c, f0, f1),
            64'(ch_bus(c)), 64'(bus_of(owner(c, f0, f1))));
  endtask

  task automatic t_reset;
    rd_check("R7 setup reset", 8'h00, 32'h0);
    rd_check("R7 psel reset", 8'h1C, 32'h0);
    rd_check("R7 gsrc reset", 8'h20, 32'h0);
    check_routes("R7 route", 0, 0);
    check("R7 hdmi idle", 64'({hdmi_data, hdmi_valid}), 64'(0));
    check("R7 enables", 64'({clk_en_tv0, clk_en_tv1, clk_en_dsi}), 64'(0));
  endtask

  task automatic t_route_basic;
    wr(8'h1C, 32'h0000_0010);  // mixer0 -> ch0, mixer1 -> ch1
    check_routes("R1 straight", 0, 1);
    wr(8'h1C, 32'h0000_0001);  // mixer0 -> ch1, mixer1 -> ch0
    check_routes("R1 swapped", 1, 0);
  endtask

  task automatic t_conflict;
    wr(8'h1C, 32'h0000_0011);  // both on ch1
    check_routes("R2 both ch1", 1, 1);
    check("R3 ch0 idle", 64'(ch_bus(0)), 64'(0));
    wr(8'h1C, 32'h0000_0000);  // both on ch0
    check("R2 both ch0", 64'(ch_bus(0)), 64'(bus_of(0)));
    check("R3 ch1 idle", 64'(ch_bus(1)), 64'(0));
  endtask

  task automatic t_invalid;
    wr(8'h1C, 32'h0000_0032);  // f0=2, f1=3
    check_routes("R4 both out of range", 2, 3);
    wr(8'h1C, 32'h0000_0013);  // f0=3, f1=1
    check_routes("R4 mixer0 out of range", 3, 1);
  endtask

  task automatic t_hdmi;
    wr(8'h1C, 32'h0000_0001);  // mixer0 on ch1, mixer1 on ch0
    for (int code = 0; code < 4; code++) begin
      wr(8'h20, 32'(code) << 28);
      check($sformatf("R5 hdmi code %0d", code),
            64'({hdmi_data, hdmi_valid, hdmi_hsync, hdmi_vsync}),
            64'((code == 1) ? bus_of(1) : (code == 2) ? bus_of(0) : bus_of(-1)));
    end
  endtask

  task automatic t_gates;
    wr(8'h20, 32'h0010_0000);
    check("R6 tv0 only", 64'({clk_en_tv0, clk_en_tv1, clk_en_dsi}), 64'(3'b100));
    wr(8'h20, 32'h0100_0000);
    check("R6 tv1 only", 64'({clk_en_tv0, clk_en_tv1, clk_en_dsi}), 64'(3'b010));
    wr(8'h20, 32'h0001_0000);
    check("R6 dsi only", 64'({clk_en_tv0, clk_en_tv1, clk_en_dsi}), 64'(3'b001));
  endtask

  task automatic t_readback;
    wr(8'h1C, 32'h0000_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h0000_0001;
    #1;
    check("R8 before edge", 64'(ch_bus(1)), 64'(0));
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    check("R8 after edge", 64'(ch_bus(1)), 64'(bus_of(0)));
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_check("R8 psel mask", 8'h1C, 32'h0000_0033);
    wr(8'h20, 32'hFFFF_FFFF);
    rd_check("R8 gsrc mask", 8'h20, 32'h3111_0000);
  endtask

  task automatic t_setup;
    wr(8'h1C, 32'h0000_0010);
    wr(8'h20, 32'h1000_0000);
    wr(8'h00, 32'hFFFF_FFEF);
    rd_check("R9 setup readback", 8'h00, 32'hFFFF_FFEF);
    check_routes("R9 routes unchanged", 0, 1);
    check("R9 hdmi unchanged", 64'(hdmi_data), 64'(D0));
    check("R9 enables unchanged", 64'({clk_en_tv0, clk_en_tv1, clk_en_dsi}), 64'(0));
  endtask

  task automatic t_unknown;
    wr(8'h24, 32'h0000_0001);
    wr(8'h1D, 32'h0000_0011);
    rd_check("R10 read other", 8'h24, 32'h0);
    rd_check("R10 psel kept", 8'h1C, 32'h0000_0010);
    check_routes("R10 routes kept", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_route_basic();
    t_conflict();
    t_invalid();
    t_hdmi();
    t_gates();
    t_readback();
    t_setup();
    t_unknown();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule